// File: doc/BRIEF.md
# Flash Page-Load and Status Emulator

This block models, in synthesizable logic, one byte-wide page-programmed flash die as its host sees it. It can stand in for a real device on an FPGA board or answer a host controller in a testbench. The block samples the active-low chip enable, write enable and output enable with the system clock and puts them through two synchronising flops. Address and data are delayed by the same two stages, so every bus value lines up with its strobe. Byte loads fill a 128-byte page buffer. When loads stop long enough, the buffer is committed to a small on-chip array.

During the simulated program period the block is busy. Reads then return a status byte instead of array data: the top bit is inverted against the last loaded byte, and bit 6 flips after every completed read. Once the period ends, reads return the stored contents. The busy flag is also brought out so a bench can see it directly.

Top module: `flash_page_emu`

## Requirements
- R1: After reset the block is idle (`busy` low, `dataOe` low) and every array byte reads as FFh.
- R2: `dataOe` is high only while the synchronised strobes show chip enable low, output enable low and write enable high, two clock edges after the pins. When idle, `dataOut` is then the array byte at the synchronised address.
- R3: A load is recognised only while output enable is high. A write pulse with output enable low opens no page and changes no data.
- R4: A write pulse whose combined low time (chip enable and write enable both low) is shorter than `MIN_LOW_CYCLES` sampled cycles is ignored. A pulse of exactly `MIN_LOW_CYCLES` is accepted.
- R5: The address is taken when the later of the two enables falls. The data is the value present in the last sampled cycle before the earlier of the two enables rises.
- R6: The first accepted load after a commit fixes the page. Later loads use only address bits 6:0 as the byte index, and their upper bits are ignored.
- R7: The program period starts once `LOAD_WINDOW` cycles have passed since the last write falling edge with no new one. Every new falling edge restarts that count.
- R8: On commit, every byte of the page that was loaded is written with its value and every byte that was not loaded is written with FFh. Earlier contents need no erase.
- R9: `busy` stays high for exactly `PROG_CYCLES` cycles. Loads attempted while busy are ignored and do not open a new page.
- R10: While busy, a read returns {inverted bit 7 of the last loaded byte, toggle bit, bits 5:0 of the last loaded byte}. The toggle bit inverts at the end of every read and holds still during a single read.
- R11: The array holds `ARRAY_PAGES` pages, selected by address bits 7 upward, `log2(ARRAY_PAGES)` bits wide. Higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Write data from host |
| dataOut | output | DATA_W | Read data or busy status |
| dataOe | output | 1 | High when the data bus should be driven |
| busy | output | 1 | High during the program period |

## Verification
Random pages are loaded with fill densities from sparse to full, in ascending and descending byte order. The upper address bits are randomised on every load after the first and on every readback. This separates correct FFh fill from stale data, and correct page fixing and aliasing from decoding of the upper bits. Directed cases cover the following:
- a write with output enable low;
- a pulse one cycle below the glitch limit, and one exactly at it;
- an address change between the two falling enables;
- a data change between the two rising enables;
- a load issued while busy.

Three reads in a row during each program period show the inverted top bit and the alternating toggle bit.

// File: rtl/flash_emu_pkg.sv
`timescale 1ns/1ps
package flash_emu_pkg;

  // Strobes handed from the control FSM to the datapath each cycle.
  typedef struct packed {
    logic latchAddr;   // later enable has fallen: capture address
    logic holdData;    // write strobe low this cycle: track data bus
    logic acceptLoad;  // valid load completed: write page buffer
    logic openPage;    // first load of a page: capture page select
    logic commitEn;    // write one buffer byte into the array
    logic clearPage;   // last busy cycle: drop loaded flags
    logic busy;        // program period active
    logic toggleBit;   // current status toggle value
  } emuStrobes_t;

endpackage

// File: rtl/flash_emu_ctrl.sv
`timescale 1ns/1ps
module flash_emu_ctrl
  import flash_emu_pkg::*;
#(
  parameter int PAGE_W         = 7,
  parameter int MIN_LOW_CYCLES = 2,
  parameter int LOAD_WINDOW    = 18750,
  parameter int PROG_CYCLES    = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  output emuStrobes_t       strobes,
  output logic [PAGE_W-1:0] commitIdx,
  output logic              dataOe
);

  localparam int LCW = $clog2(MIN_LOW_CYCLES + 1) + 1;
  localparam int TW  = $clog2(LOAD_WINDOW + 1) + 1;
  localparam int PW  = $clog2(PROG_CYCLES + 1) + 1;
  localparam logic [LCW-1:0] MIN_V   = LCW'(MIN_LOW_CYCLES);
  localparam logic [TW-1:0]  WIN_V   = TW'(LOAD_WINDOW);
  localparam logic [PW-1:0]  LAST_V  = PW'(PROG_CYCLES - 1);
  localparam logic [PW-1:0]  BYTES_V = PW'(1 << PAGE_W);

  // [0],[1] synchroniser stages, [2] previous synchronised value
  logic [2:0] ceSync, weSync, oeSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSync <= '1;
      weSync <= '1;
      oeSync <= '1;
    end else begin
      ceSync <= {ceSync[1:0], ceN};
      weSync <= {weSync[1:0], weN};
      oeSync <= {oeSync[1:0], oeN};
    end
  end

  logic wrNow, wrPrev, rdNow, rdPrev, fallEv, riseEv;
  assign wrNow  = !ceSync[1] && !weSync[1] && oeSync[1];
  assign wrPrev = !ceSync[2] && !weSync[2] && oeSync[2];
  assign rdNow  = !ceSync[1] && !oeSync[1] && weSync[1];
  assign rdPrev = !ceSync[2] && !oeSync[2] && weSync[2];
  assign fallEv = wrNow && !wrPrev;
  assign riseEv = !wrNow && wrPrev;

  logic [LCW-1:0] lowCnt;
  logic [TW-1:0]  loadTimer;
  logic [PW-1:0]  progCnt;
  logic           busyQ, pageOpen, toggleQ;
  logic           loadOk, commitStart;

  assign loadOk      = riseEv && (lowCnt >= MIN_V) && !busyQ;
  assign commitStart = pageOpen && !busyQ && !wrNow && (loadTimer >= WIN_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt    <= '0;
      loadTimer <= '0;
      progCnt   <= '0;
      busyQ     <= 1'b0;
      pageOpen  <= 1'b0;
      toggleQ   <= 1'b0;
    end else begin
      if (!wrNow)            lowCnt <= '0;
      else if (lowCnt != '1) lowCnt <= lowCnt + 1'b1;

      if (fallEv)                 loadTimer <= '0;
      else if (loadTimer < WIN_V) loadTimer <= loadTimer + 1'b1;

      if (loadOk) pageOpen <= 1'b1;

      if (commitStart) begin
        busyQ   <= 1'b1;
        progCnt <= '0;
      end else if (busyQ) begin
        progCnt <= progCnt + 1'b1;
        if (progCnt == LAST_V) begin
          busyQ    <= 1'b0;
          pageOpen <= 1'b0;
        end
      end

      if (busyQ && rdPrev && !rdNow) toggleQ <= ~toggleQ;
    end
  end

  always_comb begin
    strobes.latchAddr  = fallEv;
    strobes.holdData   = wrNow;
    strobes.acceptLoad = loadOk;
    strobes.openPage   = loadOk && !pageOpen;
    strobes.commitEn   = busyQ && (progCnt < BYTES_V);
    strobes.clearPage  = busyQ && (progCnt == LAST_V);
    strobes.busy       = busyQ;
    strobes.toggleBit  = toggleQ;
  end

  assign commitIdx = progCnt[PAGE_W-1:0];
  assign dataOe    = rdNow;

endmodule

// File: rtl/flash_emu_dp.sv
`timescale 1ns/1ps
module flash_emu_dp
  import flash_emu_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 7,
  parameter int ARRAY_PAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  emuStrobes_t       strobes,
  input  logic [PAGE_W-1:0] commitIdx,
  output logic [DATA_W-1:0] dataOut
);

  localparam int SEL_W      = $clog2(ARRAY_PAGES);
  localparam int USED_W     = PAGE_W + SEL_W;
  localparam int DEPTH      = 1 << USED_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [USED_W-1:0] addrS1, addrS2, latchedAddr;
  logic [DATA_W-1:0] dataS1, dataS2, dataHold, lastByte;
  logic [SEL_W-1:0]  pageReg;
  logic [PAGE_BYTES-1:0] loadedMask;
  logic [DATA_W-1:0] pageBuf  [PAGE_BYTES];
  logic [DATA_W-1:0] memArray [DEPTH];
  logic [PAGE_W-1:0] byteIdx;

  assign byteIdx = latchedAddr[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS1      <= '0;
      addrS2      <= '0;
      dataS1      <= '0;
      dataS2      <= '0;
      dataHold    <= '0;
      latchedAddr <= '0;
      lastByte    <= '0;
      pageReg     <= '0;
      loadedMask  <= '0;
    end else begin
      addrS1 <= addr[USED_W-1:0];
      addrS2 <= addrS1;
      dataS1 <= dataIn;
      dataS2 <= dataS1;
      if (strobes.holdData)  dataHold    <= dataS2;
      if (strobes.latchAddr) latchedAddr <= addrS2;
      if (strobes.openPage)  pageReg     <= latchedAddr[USED_W-1:PAGE_W];
      if (strobes.acceptLoad) begin
        lastByte            <= dataHold;
        loadedMask[byteIdx] <= 1'b1;
      end
      if (strobes.clearPage) loadedMask <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.acceptLoad) pageBuf[byteIdx] <= dataHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArray[i] <= '1;
    end else if (strobes.commitEn) begin
      memArray[{pageReg, commitIdx}] <= loadedMask[commitIdx] ? pageBuf[commitIdx] : '1;
    end
  end

  always_comb begin
    if (strobes.busy)
      dataOut = {~lastByte[DATA_W-1], strobes.toggleBit, lastByte[DATA_W-3:0]};
    else
      dataOut = memArray[addrS2];
  end

endmodule

// File: rtl/flash_page_emu.sv
`timescale 1ns/1ps
module flash_page_emu
  import flash_emu_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int PAGE_W         = 7,
  parameter int ARRAY_PAGES    = 4,
  parameter int MIN_LOW_CYCLES = 2,
  parameter int LOAD_WINDOW    = 18750,
  parameter int PROG_CYCLES    = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busy
);

  emuStrobes_t       strobes;
  logic [PAGE_W-1:0] commitIdx;

  flash_emu_ctrl #(
    .PAGE_W(PAGE_W), .MIN_LOW_CYCLES(MIN_LOW_CYCLES),
    .LOAD_WINDOW(LOAD_WINDOW), .PROG_CYCLES(PROG_CYCLES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .strobes(strobes), .commitIdx(commitIdx), .dataOe(dataOe)
  );

  flash_emu_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .ARRAY_PAGES(ARRAY_PAGES)
  ) dp (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .strobes(strobes), .commitIdx(commitIdx), .dataOut(dataOut)
  );

  assign busy = strobes.busy;

endmodule

// File: rtl/flash_page_emu_chk.sv
`timescale 1ns/1ps
module flash_page_emu_chk #(
  parameter int DATA_W      = 8,
  parameter int LOAD_WINDOW = 18750,
  parameter int PROG_CYCLES = 625000
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              weN,
  input logic              oeN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              busy
);

  localparam int TW = $clog2(LOAD_WINDOW + 2) + 1;
  localparam int PW = $clog2(PROG_CYCLES + 2) + 1;
  localparam logic [TW-1:0] WIN_V  = TW'(LOAD_WINDOW);
  localparam logic [PW-1:0] PROG_V = PW'(PROG_CYCLES);

  logic          pinWrPrev;
  logic [TW-1:0] sinceFall;
  logic [PW-1:0] busyRun;
  logic          pinWr;
  assign pinWr = !ceN && !weN && oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinWrPrev <= 1'b0;
      sinceFall <= '0;
      busyRun   <= '0;
    end else begin
      pinWrPrev <= pinWr;
      if (pinWr && !pinWrPrev)  sinceFall <= '0;
      else if (sinceFall != '1) sinceFall <= sinceFall + 1'b1;
      busyRun <= busy ? busyRun + 1'b1 : '0;
    end
  end

  // R2
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(!ceN && !oeN && weN, 2));

  // R7
  commit_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (sinceFall >= WIN_V));

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == PROG_V));

  // R10
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataOe && $past(busy && dataOe)) |-> $stable(dataOut));

endmodule

bind flash_page_emu flash_page_emu_chk #(
  .DATA_W(DATA_W), .LOAD_WINDOW(LOAD_WINDOW), .PROG_CYCLES(PROG_CYCLES)
) chkInst (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
  .dataOut(dataOut), .dataOe(dataOe), .busy(busy)
);

// File: tb/flash_page_emu_test.sv
`timescale 1ns/1ps
module flash_page_emu_test;

  localparam int LW = 200;
  localparam int PC = 400;
  localparam int ML = 3;
  localparam int AP = 4;

  logic clk = 1'b0, rstN = 1'b0, ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe, busy;

  always #4 clk = ~clk;

  flash_page_emu #(
    .ADDR_W(17), .DATA_W(8), .PAGE_W(7), .ARRAY_PAGES(AP),
    .MIN_LOW_CYCLES(ML), .LOAD_WINDOW(LW), .PROG_CYCLES(PC)
  ) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .busy(busy)
  );

  int checks = 0, failures = 0, cycle = 0;
  int lastFallCycle = 0, riseCycle = 0, runLen = 0, lastRun = 0;
  logic prevBusy = 1'b0;
  bit finished = 0;

  logic [7:0] memModel [AP*128];
  logic [7:0] pendBuf  [128];
  bit         pendHave [128];
  logic [7:0] pendLast;
  int         pendPage;

  always @(posedge clk) cycle++;

  always @(negedge clk) begin
    if (busy === 1'b1 && !prevBusy) riseCycle = cycle;
    if (busy === 1'b1) runLen++;
    else if (prevBusy) begin lastRun = runLen; runLen = 0; end
    prevBusy = (busy === 1'b1);
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus(logic [7:0] last, logic b6);
    return {~last[7], b6, last[5:0]};
  endfunction

  function automatic logic [7:0] expCommit(bit have, logic [7:0] d);
    return have ? d : 8'hFF;
  endfunction

  task automatic loadByte(logic [16:0] a, logic [7:0] d, int low);
    @(negedge clk); addr = a; dataIn = d; oeN = 1'b1; weN = 1'b1; ceN = 1'b1;
    @(negedge clk); ceN = 1'b0; weN = 1'b0; lastFallCycle = cycle;
    repeat (low) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readByte(logic [16:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk); addr = a; weN = 1'b1; ceN = 1'b0; oeN = 1'b0;
    repeat (4) @(negedge clk);
    v = dataOut; oe = dataOe;
    ceN = 1'b1; oeN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic clearPend(int pg);
    pendPage = pg;
    for (int i = 0; i < 128; i++) begin pendHave[i] = 0; pendBuf[i] = 8'h00; end
  endtask

  task automatic recordLoad(int idx, logic [7:0] d);
    pendHave[idx] = 1; pendBuf[idx] = d; pendLast = d;
  endtask

  task automatic finishPage();
    int waited;
    int gap;
    logic [7:0] r1, r2, r3, v;
    logic o1, o2, o3, oe;
    logic [16:0] a;
    waited = 0;
    while (busy !== 1'b1 && waited < LW + 60) begin @(negedge clk); waited++; end
    @(negedge clk);
    gap = riseCycle - lastFallCycle;
    check(busy === 1'b1, "R7 program period starts", busy, 1);
    check(gap >= LW && gap <= LW + 6, "R7 start after quiet window", gap, LW);
    // R10 status reads while busy
    readByte(17'($urandom), r1, o1);
    check(o1 === 1'b1 && r1 === expStatus(pendLast, r1[6]), "R10 busy status", r1, expStatus(pendLast, r1[6]));
    readByte(17'($urandom), r2, o2);
    check(r2 === expStatus(pendLast, ~r1[6]), "R10 toggle flips", r2, expStatus(pendLast, ~r1[6]));
    readByte(17'($urandom), r3, o3);
    check(r3 === expStatus(pendLast, r1[6]), "R10 toggle flips back", r3, expStatus(pendLast, r1[6]));
    // R9 load while busy must be ignored
    a = 17'($urandom); a[8:7] = 2'(pendPage);
    loadByte(a, ~memModel[pendPage*128 + int'(a[6:0])] ^ 8'h01, ML + 2);
    waited = 0;
    while (busy === 1'b1 && waited < PC + 60) begin @(negedge clk); waited++; end
    @(negedge clk);
    check(busy === 1'b0 && lastRun == PC, "R9 busy length", lastRun, PC);
    repeat (LW + 30) @(negedge clk);
    check(busy === 1'b0, "R9 load while busy opens no page", busy, 0);
    for (int i = 0; i < 128; i++)
      memModel[pendPage*128 + i] = expCommit(pendHave[i], pendBuf[i]);
    for (int i = 0; i < 128; i++) begin
      a = 17'($urandom); a[8:7] = 2'(pendPage); a[6:0] = 7'(i);
      readByte(a, v, oe);
      check(oe === 1'b1 && v === memModel[pendPage*128 + i], "R6 R8 R11 readback",
            v, memModel[pendPage*128 + i]);
    end
  endtask

  task automatic randomRound(int pg, int fill, bit rev);
    bit first;
    logic [16:0] a;
    logic [7:0] d;
    int i;
    clearPend(pg);
    first = 1;
    for (int k = 0; k < 128; k++) begin
      i = rev ? 127 - k : k;
      if (int'($urandom % 100) < fill || (k == 127 && first)) begin
        d = 8'($urandom);
        a = 17'($urandom); a[6:0] = 7'(i);
        if (first) a[8:7] = 2'(pg);
        loadByte(a, d, ML + int'($urandom % 4));
        recordLoad(i, d);
        first = 0;
      end
    end
    finishPage();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog R7 R9 run hung actual=%0d expected=%0d", cycle, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe;
    void'($urandom(32'd51413));
    for (int i = 0; i < AP*128; i++) memModel[i] = 8'hFF;
    repeat (5) @(negedge clk);
    check(busy === 1'b0, "R1 reset busy", busy, 0);
    check(dataOe === 1'b0, "R1 reset dataOe", dataOe, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    readByte(17'h00155, v, oe);
    check(v === 8'hFF, "R1 erased array", v, 8'hFF);
    check(oe === 1'b1, "R2 read drives bus", oe, 1);

    // R2 no drive with write enable low, or with chip disabled
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; weN = 1'b0;
    repeat (4) @(negedge clk);
    check(dataOe === 1'b0, "R2 no drive while write enable low", dataOe, 0);
    ceN = 1'b1; weN = 1'b1;
    repeat (4) @(negedge clk);
    check(dataOe === 1'b0, "R2 no drive while chip disabled", dataOe, 0);
    oeN = 1'b1;
    repeat (3) @(negedge clk);

    // R3 write attempt with output enable low
    @(negedge clk); addr = {8'h00, 2'd3, 7'd4}; dataIn = 8'h3A; oeN = 1'b0;
    @(negedge clk); ceN = 1'b0; weN = 1'b0;
    repeat (ML + 2) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    @(negedge clk); oeN = 1'b1;
    repeat (LW + 30) @(negedge clk);
    check(busy === 1'b0, "R3 blocked load opens no page", busy, 0);
    readByte({8'h00, 2'd3, 7'd4}, v, oe);
    check(v === 8'hFF, "R3 blocked load leaves data", v, 8'hFF);

    // R4 glitch below limit, then pulse at limit
    loadByte({8'h00, 2'd2, 7'd9}, 8'h42, ML - 1);
    repeat (LW + 30) @(negedge clk);
    check(busy === 1'b0, "R4 short pulse ignored", busy, 0);
    readByte({8'h00, 2'd2, 7'd9}, v, oe);
    check(v === 8'hFF, "R4 short pulse leaves data", v, 8'hFF);
    clearPend(2);
    loadByte({8'h00, 2'd2, 7'd9}, 8'h42, ML);
    recordLoad(9, 8'h42);
    finishPage();
    readByte({8'h00, 2'd2, 7'd9}, v, oe);
    check(v === 8'h42, "R4 pulse at limit accepted", v, 8'h42);

    // R5 address at later falling edge, data before earlier rising edge
    clearPend(1);
    @(negedge clk); addr = {8'h00, 2'd1, 7'd77}; dataIn = 8'h11; oeN = 1'b1; ceN = 1'b0;
    repeat (2) @(negedge clk); addr = {8'h3C, 2'd1, 7'd20};
    @(negedge clk); weN = 1'b0; lastFallCycle = cycle;
    repeat (2) @(negedge clk); addr = 17'h1FFFF; dataIn = 8'hA7;
    repeat (2) @(negedge clk); weN = 1'b1;
    @(negedge clk); dataIn = 8'h22;
    repeat (2) @(negedge clk); ceN = 1'b1;
    repeat (4) @(negedge clk);
    recordLoad(20, 8'hA7);
    finishPage();
    readByte({8'h00, 2'd1, 7'd20}, v, oe);
    check(v === 8'hA7, "R5 split strobe capture", v, 8'hA7);
    readByte({8'h00, 2'd1, 7'd77}, v, oe);
    check(v === 8'hFF, "R5 early address not used", v, 8'hFF);

    randomRound(0, 100, 0);
    randomRound(3, 60, 1);
    randomRound(2, 20, 0);
    randomRound(1, 85, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule